// File: doc/BRIEF.md
# Paged Memory Window Controller

This block sits between an 8-bit processor's 16-bit address bus and a set of ROM and RAM devices. The address space is cut into eight 8 KB read windows. Two configuration registers on the I/O bus choose the source of each window. Each 4-bit field in these registers picks the sources for a pair of adjacent windows. A third register gates RAM writes separately for each of the four 16 KB regions. For every access, the block reports which device answers and the offset inside that device. For writes, it also produces a gated write strobe. The memory arrays themselves sit outside the block.

Two side controls change the read map. A bit in a font-control register selects which 16 KB half of the font ROM the font codes use. An active-low character-switch input replaces window 3 with character-generator ROM for as long as it is held low. When the input is released, the window falls back to its programmed source.

Top module: `bank_map_ctrl`

## Requirements
- R1: `cpu_addr[15:13]` picks the read window. `rd_dev` codes are: 0 empty (reads as zero), 1 main ROM, 2 font ROM, 3 cartridge, 4 RAM, 5 voice ROM, 6 character ROM. For RAM, `rd_off` equals `cpu_addr`. For every other device, `rd_off` = {1'b0, page[1:0], `cpu_addr[12:0]`}.
- R2: Register 0xF0 bits 3:0 set the source of windows 0-1, and bits 7:4 set windows 2-3. Register 0xF1 bits 3:0 set windows 4-5, and bits 7:4 set windows 6-7.
- R3: A field code gives the pair (even window, odd window) as follows. Code 0, E and F give empty/empty. Code 1 gives M/M+1, where M is main page 0 in a low field and main page 2 in a high field. Code 2 gives font/font. Code 3 gives cart page 1 twice, and code 4 gives cart page 0 twice. Code 5 gives font/main M+1. Code 6 gives main M/font. Code 7 gives cart 0/cart 1, and code 8 gives cart 1/cart 0. Code 9 gives cart 1/main M+1. Code A gives main M/cart 1. Code B gives cart 0/font. Code C gives font/cart 0. Code D gives RAM at the same address.
- R4: In the high field of 0xF0 only, each font slot reads the voice ROM instead: the even window uses voice page 0 and the odd window uses voice page 1.
- R5: Font slots use font page 2*h for the even window and 2*h+1 for the odd window, where h is bit 1 of the last value written to port 0xC2.
- R6: Register 0xF2 bits 0, 2, 4 and 6 enable writes to 16 KB regions 0, 1, 2 and 3. `wr_strobe` is `mem_wr` ANDed with the enable bit chosen by `cpu_addr[15:14]`. `wr_off` equals `cpu_addr`. A write to a disabled region produces no strobe.
- R7: After reset, 0xF0 holds 0x11 and 0xF1 holds 0xDD. Windows 0-3 read main ROM pages 0-3, windows 4-7 read RAM, and writes are enabled only in regions 2 and 3.
- R8: `chr_sel_n` is registered. In the cycle after it is seen low, window 3 reads character ROM page 0. In the cycle after it is seen high again, window 3 returns to the mapping set by 0xF0.
- R9: `io_rdata` returns the held value when `io_addr` is 0xF0 or 0xF1. For any other port address it returns 0xFF.
- R10: A register write takes effect in the cycle after `io_wr`. An access in the same cycle as the write still sees the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor memory address |
| mem_wr | input | 1 | Memory write request |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| chr_sel_n | input | 1 | Character-ROM override, active low |
| rd_dev | output | 3 | Device answering the read |
| rd_off | output | 16 | Offset inside that device |
| wr_strobe | output | 1 | Gated RAM write strobe |
| wr_off | output | 16 | RAM write offset |
| io_rdata | output | 8 | I/O read data |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address and 13-bit window offsets, which give eight windows, four field pairs and four write regions. With these sizes, random register values reach all sixteen field codes in every pair position, including the voice-ROM substitution and both font halves. Addresses chosen at random across all 64 KB reach every window and region. Directed cases cover the reset map, toggling of the character override, disabled-region writes and a read in the same cycle as a register write.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  typedef enum logic [2:0] {
    DEV_NONE  = 3'd0,
    DEV_MAIN  = 3'd1,
    DEV_FONT  = 3'd2,
    DEV_CART  = 3'd3,
    DEV_RAM   = 3'd4,
    DEV_VOICE = 3'd5,
    DEV_CHAR  = 3'd6
  } dev_e;

  typedef struct packed {
    dev_e       dev;
    logic [1:0] page;
  } win_src_t;

  // slot kinds inside a pair code
  typedef enum logic [2:0] {
    SLOT_EMPTY = 3'd0,
    SLOT_MAIN  = 3'd1,
    SLOT_FONT  = 3'd2,
    SLOT_CLO   = 3'd3,
    SLOT_CHI   = 3'd4,
    SLOT_RAM   = 3'd5
  } slot_e;

endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs #(
  parameter int          NUM_REGION = 4,
  parameter logic [7:0]  PORT_RD_LO = 8'hF0,
  parameter logic [7:0]  PORT_RD_HI = 8'hF1,
  parameter logic [7:0]  PORT_WEN   = 8'hF2,
  parameter logic [7:0]  PORT_FONT  = 8'hC2,
  parameter logic [7:0]  RST_RD_LO  = 8'h11,
  parameter logic [7:0]  RST_RD_HI  = 8'hDD,
  parameter logic [7:0]  RST_WEN    = 8'h50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic [7:0]            io_addr,
  input  logic [7:0]            io_wdata,
  input  logic                  chr_sel_n,
  output logic [7:0]            rd_lo,
  output logic [7:0]            rd_hi,
  output logic [NUM_REGION-1:0] wen,
  output logic                  font_half,
  output logic                  chr_low,
  output logic [7:0]            io_rdata
);

  logic [7:0]            rd_lo_d, rd_hi_d;
  logic [NUM_REGION-1:0] wen_d, wen_rst, wen_from_bus;
  logic                  font_half_d, chr_low_d;
  logic                  hit_lo, hit_hi, hit_wen, hit_font;

  // even bits of the write-enable port map to regions
  for (genvar r = 0; r < NUM_REGION; r++) begin : g_wen_bits
    assign wen_from_bus[r] = io_wdata[2*r];
    assign wen_rst[r]      = RST_WEN[2*r];
  end

  assign hit_lo   = io_wr && (io_addr == PORT_RD_LO);
  assign hit_hi   = io_wr && (io_addr == PORT_RD_HI);
  assign hit_wen  = io_wr && (io_addr == PORT_WEN);
  assign hit_font = io_wr && (io_addr == PORT_FONT);

  always_comb begin
    rd_lo_d     = rd_lo;
    rd_hi_d     = rd_hi;
    wen_d       = wen;
    font_half_d = font_half;
    chr_low_d   = !chr_sel_n;
    if (hit_lo)   rd_lo_d     = io_wdata;
    if (hit_hi)   rd_hi_d     = io_wdata;
    if (hit_wen)  wen_d       = wen_from_bus;
    if (hit_font) font_half_d = io_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lo     <= RST_RD_LO;
      rd_hi     <= RST_RD_HI;
      wen       <= wen_rst;
      font_half <= 1'b0;
      chr_low   <= 1'b0;
    end else begin
      rd_lo     <= rd_lo_d;
      rd_hi     <= rd_hi_d;
      wen       <= wen_d;
      font_half <= font_half_d;
      chr_low   <= chr_low_d;
    end
  end

  always_comb begin
    if (io_addr == PORT_RD_LO)      io_rdata = rd_lo;
    else if (io_addr == PORT_RD_HI) io_rdata = rd_hi;
    else                            io_rdata = 8'hFF;
  end

endmodule

// File: rtl/bank_pair_decode.sv
module bank_pair_decode
  import bank_map_pkg::*;
#(
  parameter bit UPPER     = 1'b0,
  parameter bit VOICE_ALT = 1'b0
) (
  input  logic [3:0] code,
  input  logic       font_half,
  output win_src_t   even_src,
  output win_src_t   odd_src
);

  localparam logic [1:0] MAIN_BASE = UPPER ? 2'd2 : 2'd0;

  slot_e even_kind, odd_kind;

  always_comb begin
    even_kind = SLOT_EMPTY;
    odd_kind  = SLOT_EMPTY;
    unique case (code)
      4'h1: begin even_kind = SLOT_MAIN;  odd_kind = SLOT_MAIN;  end
      4'h2: begin even_kind = SLOT_FONT;  odd_kind = SLOT_FONT;  end
      4'h3: begin even_kind = SLOT_CHI;   odd_kind = SLOT_CHI;   end
      4'h4: begin even_kind = SLOT_CLO;   odd_kind = SLOT_CLO;   end
      4'h5: begin even_kind = SLOT_FONT;  odd_kind = SLOT_MAIN;  end
      4'h6: begin even_kind = SLOT_MAIN;  odd_kind = SLOT_FONT;  end
      4'h7: begin even_kind = SLOT_CLO;   odd_kind = SLOT_CHI;   end
      4'h8: begin even_kind = SLOT_CHI;   odd_kind = SLOT_CLO;   end
      4'h9: begin even_kind = SLOT_CHI;   odd_kind = SLOT_MAIN;  end
      4'hA: begin even_kind = SLOT_MAIN;  odd_kind = SLOT_CHI;   end
      4'hB: begin even_kind = SLOT_CLO;   odd_kind = SLOT_FONT;  end
      4'hC: begin even_kind = SLOT_FONT;  odd_kind = SLOT_CLO;   end
      4'hD: begin even_kind = SLOT_RAM;   odd_kind = SLOT_RAM;   end
      default: begin even_kind = SLOT_EMPTY; odd_kind = SLOT_EMPTY; end
    endcase
  end

  function automatic win_src_t slot_to_src(slot_e kind, logic odd, logic fh);
    win_src_t s;
    s.dev  = DEV_NONE;
    s.page = 2'd0;
    case (kind)
      SLOT_MAIN: begin s.dev = DEV_MAIN; s.page = MAIN_BASE | {1'b0, odd}; end
      SLOT_FONT: begin
        if (VOICE_ALT) begin s.dev = DEV_VOICE; s.page = {1'b0, odd}; end
        else           begin s.dev = DEV_FONT;  s.page = {fh, odd};   end
      end
      SLOT_CLO:  begin s.dev = DEV_CART; s.page = 2'd0; end
      SLOT_CHI:  begin s.dev = DEV_CART; s.page = 2'd1; end
      SLOT_RAM:  begin s.dev = DEV_RAM;  s.page = 2'd0; end
      default:   begin s.dev = DEV_NONE; s.page = 2'd0; end
    endcase
    return s;
  endfunction

  assign even_src = slot_to_src(even_kind, 1'b0, font_half);
  assign odd_src  = slot_to_src(odd_kind,  1'b1, font_half);

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         PAGE_W     = 13,
  parameter int         CHAR_WIN   = 3,
  parameter logic [7:0] PORT_RD_LO = 8'hF0,
  parameter logic [7:0] PORT_RD_HI = 8'hF1,
  parameter logic [7:0] PORT_WEN   = 8'hF2,
  parameter logic [7:0] PORT_FONT  = 8'hC2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              chr_sel_n,
  output logic [2:0]        rd_dev,
  output logic [ADDR_W-1:0] rd_off,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_off,
  output logic [7:0]        io_rdata
);

  localparam int WIN_W      = ADDR_W - PAGE_W;
  localparam int NUM_WIN    = 1 << WIN_W;
  localparam int NUM_PAIR   = NUM_WIN / 2;
  localparam int NUM_REGION = NUM_WIN / 2;
  localparam int PAD_W      = ADDR_W - PAGE_W - 2;

  logic [7:0]            rd_lo, rd_hi;
  logic [NUM_REGION-1:0] wen;
  logic                  font_half, chr_low;
  logic [15:0]           field_vec;
  win_src_t              wins [NUM_WIN];
  win_src_t              sel_src;
  logic [WIN_W-1:0]      win_idx;
  logic [WIN_W-2:0]      region_idx;

  bank_cfg_regs #(
    .NUM_REGION (NUM_REGION),
    .PORT_RD_LO (PORT_RD_LO),
    .PORT_RD_HI (PORT_RD_HI),
    .PORT_WEN   (PORT_WEN),
    .PORT_FONT  (PORT_FONT)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .chr_sel_n (chr_sel_n),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .wen       (wen),
    .font_half (font_half),
    .chr_low   (chr_low),
    .io_rdata  (io_rdata)
  );

  assign field_vec = {rd_hi, rd_lo};

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    bank_pair_decode #(
      .UPPER     (p[0]),
      .VOICE_ALT (p == 1)
    ) u_dec (
      .code      (field_vec[4*p +: 4]),
      .font_half (font_half),
      .even_src  (wins[2*p]),
      .odd_src   (wins[2*p+1])
    );
  end

  assign win_idx    = cpu_addr[ADDR_W-1:PAGE_W];
  assign region_idx = cpu_addr[ADDR_W-1:PAGE_W+1];

  always_comb begin
    sel_src = wins[win_idx];
    if (chr_low && (win_idx == WIN_W'(CHAR_WIN))) begin
      sel_src.dev  = DEV_CHAR;
      sel_src.page = 2'd0;
    end
  end

  always_comb begin
    rd_dev = sel_src.dev;
    if (sel_src.dev == DEV_RAM) rd_off = cpu_addr;
    else rd_off = {{PAD_W{1'b0}}, sel_src.page, cpu_addr[PAGE_W-1:0]};
  end

  assign wr_strobe = mem_wr && wen[region_idx];
  assign wr_off    = cpu_addr;

endmodule

// File: rtl/bank_map_chk.sv
module bank_map_chk
  import bank_map_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         PAGE_W     = 13,
  parameter logic [7:0] PORT_RD_LO = 8'hF0,
  parameter logic [7:0] PORT_RD_HI = 8'hF1,
  parameter logic [7:0] PORT_WEN   = 8'hF2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_wr,
  input logic              io_wr,
  input logic [7:0]        io_addr,
  input logic [7:0]        io_wdata,
  input logic              chr_sel_n,
  input logic [2:0]        rd_dev,
  input logic [ADDR_W-1:0] rd_off,
  input logic              wr_strobe,
  input logic [7:0]        io_rdata
);

  // R1: RAM windows pass the address through unchanged
  assert_ram_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dev == DEV_RAM) |-> (rd_off == cpu_addr));

  // R4: voice ROM only appears in windows 2-3
  assert_voice_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dev == DEV_VOICE) |-> (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'd1));

  // R6: region 0 disabled by the previous write of the enable port
  assert_wr_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'd0 &&
     $past(io_wr && io_addr == PORT_WEN && !io_wdata[0])) |-> !wr_strobe);

  // R6: no strobe without a request
  assert_wr_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |-> !wr_strobe);

  // R8: character override held for two samples
  assert_chr_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chr_sel_n && $past(!chr_sel_n) && cpu_addr[ADDR_W-1:PAGE_W] == 3'd3)
      |-> (rd_dev == DEV_CHAR));

  // R9: readback of the last written value
  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && io_addr == PORT_RD_HI && $past(io_wr && io_addr == PORT_RD_HI))
      |-> (io_rdata == $past(io_wdata)));

  // R9: unmapped ports float high
  assert_other_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != PORT_RD_LO && io_addr != PORT_RD_HI) |-> (io_rdata == 8'hFF));

endmodule

bind bank_map_ctrl bank_map_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_W     (PAGE_W),
  .PORT_RD_LO (PORT_RD_LO),
  .PORT_RD_HI (PORT_RD_HI),
  .PORT_WEN   (PORT_WEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .mem_wr    (mem_wr),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .chr_sel_n (chr_sel_n),
  .rd_dev    (rd_dev),
  .rd_off    (rd_off),
  .wr_strobe (wr_strobe),
  .io_rdata  (io_rdata)
);

// File: tb/tb_bank_map_ctrl.sv
module tb_bank_map_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mem_wr;
  logic        io_wr;
  logic [7:0]  io_addr;
  logic [7:0]  io_wdata;
  logic        chr_sel_n;
  logic [2:0]  rd_dev;
  logic [15:0] rd_off;
  logic        wr_strobe;
  logic [15:0] wr_off;
  logic [7:0]  io_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model of the configuration
  logic [7:0] m_lo, m_hi;
  logic [3:0] m_wen;
  logic       m_fh, m_chr;

  always #4 clk = ~clk;

  bank_map_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_wr(mem_wr),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .chr_sel_n(chr_sel_n), .rd_dev(rd_dev), .rd_off(rd_off),
    .wr_strobe(wr_strobe), .wr_off(wr_off), .io_rdata(io_rdata)
  );

  // kind: 0 empty,1 main,2 font,3 cart lo,4 cart hi,5 ram  (R3)
  function automatic int slot_kind(logic [3:0] c, bit odd);
    case (c)
      4'h1: return 1;
      4'h2: return 2;
      4'h3: return 4;
      4'h4: return 3;
      4'h5: return odd ? 1 : 2;
      4'h6: return odd ? 2 : 1;
      4'h7: return odd ? 4 : 3;
      4'h8: return odd ? 3 : 4;
      4'h9: return odd ? 1 : 4;
      4'hA: return odd ? 4 : 1;
      4'hB: return odd ? 2 : 3;
      4'hC: return odd ? 3 : 2;
      4'hD: return 5;
      default: return 0;
    endcase
  endfunction

  // returns {dev[2:0], off[15:0]}
  function automatic logic [18:0] exp_read(logic [15:0] a);
    int          w;
    logic [3:0]  c;
    bit          odd;
    int          k;
    logic [2:0]  dev;
    logic [1:0]  pg;
    w   = int'(a[15:13]);
    odd = a[13];
    c   = (w < 2) ? m_lo[3:0] : (w < 4) ? m_lo[7:4] :
          (w < 6) ? m_hi[3:0] : m_hi[7:4];
    k   = slot_kind(c, odd);
    dev = 3'd0; pg = 2'd0;
    case (k)
      1: begin dev = 3'd1; pg = {a[14], odd}; end
      2: begin
        if (w == 2 || w == 3) begin dev = 3'd5; pg = {1'b0, odd}; end
        else                  begin dev = 3'd2; pg = {m_fh, odd}; end
      end
      3: begin dev = 3'd3; pg = 2'd0; end
      4: begin dev = 3'd3; pg = 2'd1; end
      5: dev = 3'd4;
      default: dev = 3'd0;
    endcase
    if (w == 3 && m_chr) begin dev = 3'd6; pg = 2'd0; end
    if (dev == 3'd4) return {dev, a};
    return {dev, 1'b0, pg, a[12:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_rd(string req, logic [15:0] a);
    logic [18:0] e;
    cpu_addr = a;
    #1;
    e = exp_read(a);
    check(req, {13'd0, rd_dev, rd_off}, {13'd0, e});
  endtask

  task automatic check_wr(string req, logic [15:0] a);
    cpu_addr = a;
    mem_wr   = 1'b1;
    #1;
    check(req, {15'd0, wr_strobe, wr_off}, {15'd0, m_wen[a[15:14]], a});
    mem_wr = 1'b0;
  endtask

  task automatic check_io(string req, logic [7:0] p);
    logic [7:0] e;
    io_addr = p;
    #1;
    e = (p == 8'hF0) ? m_lo : (p == 8'hF1) ? m_hi : 8'hFF;
    check(req, {24'd0, io_rdata}, {24'd0, e});
  endtask

  task automatic model_wr(logic [7:0] p, logic [7:0] d);
    case (p)
      8'hF0: m_lo = d;
      8'hF1: m_hi = d;
      8'hF2: m_wen = {d[6], d[4], d[2], d[0]};
      8'hC2: m_fh = d[1];
      default: ;
    endcase
  endtask

  task automatic io_write(logic [7:0] p, logic [7:0] d);
    io_addr  = p;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(p, d);
  endtask

  task automatic set_chr(logic v);
    chr_sel_n = v;
    @(negedge clk);
    m_chr = !v;
  endtask

  task automatic sweep_windows(string req);
    for (int w = 0; w < 8; w++) check_rd(req, {w[2:0], 13'h0A5 + 13'(w)});
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    rst_n = 1'b0; cpu_addr = '0; mem_wr = 1'b0; io_wr = 1'b0;
    io_addr = 8'h00; io_wdata = 8'h00; chr_sel_n = 1'b1;
    m_lo = 8'h11; m_hi = 8'hDD; m_wen = 4'b1100; m_fh = 1'b0; m_chr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset map
    sweep_windows("R7");
    check_io("R7", 8'hF0);
    check_io("R7", 8'hF1);
    for (int r = 0; r < 4; r++) check_wr("R7", {r[1:0], 14'h1234});

    // R9: other ports
    check_io("R9", 8'hF2);
    check_io("R9", 8'hC2);
    check_io("R9", 8'h00);

    // R10: same-cycle access sees old map, next cycle sees new
    cpu_addr = 16'h0100;
    io_addr = 8'hF0; io_wdata = 8'h0D; io_wr = 1'b1;
    #1;
    check("R10", {29'd0, rd_dev}, {29'd0, 3'd1});
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(8'hF0, 8'h0D);
    check_rd("R10", 16'h0100);

    // R4/R5: voice substitution and font half
    io_write(8'hF0, 8'h22);
    io_write(8'hF1, 8'h22);
    sweep_windows("R4");
    io_write(8'hC2, 8'h02);
    sweep_windows("R5");
    io_write(8'hF1, 8'hC5);
    sweep_windows("R5");

    // R8: character override on and off
    io_write(8'hF0, 8'h47);
    set_chr(1'b0);
    check_rd("R8", 16'h7ABC);
    check_rd("R8", 16'h4001);
    set_chr(1'b1);
    check_rd("R8", 16'h7ABC);

    // R6: disable region 0, enable region 1
    io_write(8'hF2, 8'h04);
    check_wr("R6", 16'h0010);
    check_wr("R6", 16'h5555);
    check_wr("R6", 16'hC000);

    // R2/R3: every code in every field position
    for (int c = 0; c < 16; c++) begin
      io_write(8'hF0, {c[3:0], c[3:0]});
      io_write(8'hF1, {c[3:0], c[3:0]});
      sweep_windows("R3");
    end

    // random mix: R1 R2 R3 R6 R8 R9
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0: io_write(8'hF0, 8'($urandom));
        1: io_write(8'hF1, 8'($urandom));
        2: io_write(8'hF2, 8'($urandom));
        3: io_write(8'hC2, 8'($urandom));
        4: set_chr(1'($urandom));
        default: io_write(8'($urandom), 8'($urandom));
      endcase
      check_rd("R1", 16'($urandom));
      check_rd("R2", 16'($urandom));
      check_wr("R6", 16'($urandom));
      check_io("R9", (i % 3 == 0) ? 8'hF0 : (i % 3 == 1) ? 8'hF1 : 8'($urandom));
      @(negedge clk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule